// File: doc/BRIEF.md
# In-Flight Register Writer Tracking Table

This block tracks, for every physical register of a multithreaded core, how many instructions currently in flight will write that register. It also caches a small set of condition flags describing the last value written there. A branch unit at fetch can look up a source register. When no writer is pending, the register is clean and the cached flags already settle the branch outcome. When it is dirty, the fetch side falls back to its normal predictor.

Three ports drive the table:

- **Dispatch port.** Raises the pending count of a destination register.
- **Completion port.** Lowers the count and loads fresh flags computed from the produced result.
- **Query port.** Combinationally returns the dirty bit and flags of one register. These reflect the state as of the last clock edge.

The two event ports are valid-only and never apply back-pressure: every valid event is taken in the cycle it is presented. A blocked event is reported on an error pulse instead of being stalled. Events on the same register in the same cycle are resolved inside the table.

Top module: `pending_writer_table`

## Requirements
- R1: After reset every register reads clean (query_dirty = 0) with query_flags = 7'h29, the flag pattern of a zero value.
- R2: A dispatch on a register raises its pending count by one; query_dirty for that register is 1 while the count is non-zero.
- R3: A completion on a register lowers its pending count by one; query_dirty returns to 0 in the cycle after the last pending writer completes.
- R4: On completion the flags are loaded from the result value with this encoding: bit0 = value is zero, bit1 = value is non-zero, bit2 = greater than zero, bit3 = greater than or equal to zero, bit4 = less than zero, bit5 = less than or equal to zero, bit6 = value bit 0. The value is compared as a signed number.
- R5: A dispatch and a completion on the same register in one cycle leave its count unchanged, load the flags from the completion value, and raise no error.
- R6: A dispatch alone on a register whose count is at its maximum (511) is blocked, the count stays 511, and err_overflow is 1 in that same cycle.
- R7: A completion alone on a register whose count is zero leaves the count at zero and raises err_underflow in that same cycle; the flags are still loaded from the value.
- R8: The query port shows the state as of the last clock edge: an event presented in the current cycle is not visible until after the next edge.
- R9: A dispatch and a completion on different registers in one cycle are both applied, and all other registers keep their state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch event present this cycle |
| disp_reg | input | 6 | Destination register of the dispatched instruction |
| done_valid | input | 1 | Completion event present this cycle |
| done_reg | input | 6 | Destination register of the completed instruction |
| done_value | input | 64 | Result value written by the completed instruction |
| query_reg | input | 6 | Register looked up on the query port |
| query_dirty | output | 1 | 1 when the queried register has pending writers |
| query_flags | output | 7 | Cached condition flags of the queried register |
| err_overflow | output | 1 | Pulse: a dispatch was blocked at the maximum count |
| err_underflow | output | 1 | Pulse: a completion arrived on a register with no pending writer |

## Verification
The hardest state to reach is the saturated count. Getting there takes 511 back-to-back dispatches to one register with no completion on it. The bench loops dispatches into one register to reach 511 and confirms no error pulse appears on the way. It then presents a blocked dispatch, then a paired dispatch and completion at the maximum. Finally it drains all 511 writers to show that the blocked event did not disturb the count.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int FLAG_W = 7;

  // bit0 is eq_zero ... bit6 is low_bit
  typedef struct packed {
    logic low_bit;
    logic le_zero;
    logic lt_zero;
    logic ge_zero;
    logic gt_zero;
    logic ne_zero;
    logic eq_zero;
  } cond_flags_t;

  localparam cond_flags_t ZERO_FLAGS = '{low_bit: 1'b0, le_zero: 1'b1,
                                         lt_zero: 1'b0, ge_zero: 1'b1,
                                         gt_zero: 1'b0, ne_zero: 1'b0,
                                         eq_zero: 1'b1};
endpackage

// File: rtl/result_flag_encoder.sv
module result_flag_encoder
  import pwt_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] value,
  output cond_flags_t       flags
);
  logic is_zero;
  logic is_neg;

  always_comb begin
    is_zero        = (value == '0);
    is_neg         = value[DATA_W-1];
    flags.eq_zero  = is_zero;
    flags.ne_zero  = !is_zero;
    flags.gt_zero  = !is_zero && !is_neg;
    flags.ge_zero  = !is_neg;
    flags.lt_zero  = is_neg;
    flags.le_zero  = is_neg || is_zero;
    flags.low_bit  = value[0];
  end
endmodule

// File: rtl/writer_count_entry.sv
module writer_count_entry
  import pwt_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  cond_flags_t      new_flags,
  output logic [CNT_W-1:0] count,
  output cond_flags_t      flags,
  output logic             ovf,
  output logic             unf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic only_inc;
  logic only_dec;

  always_comb begin
    only_inc = inc && !dec;
    only_dec = dec && !inc;
    ovf      = only_inc && (count == CNT_MAX);
    unf      = only_dec && (count == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      flags <= ZERO_FLAGS;
    end else begin
      if (only_inc && !ovf) count <= count + 1'b1;
      else if (only_dec && !unf) count <= count - 1'b1;
      if (dec) flags <= new_flags;
    end
  end
endmodule

// File: rtl/pending_writer_table.sv
module pending_writer_table
  import pwt_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int CNT_W    = 9,
  parameter int DATA_W   = 64,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [IDX_W-1:0]  disp_reg,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_reg,
  input  logic [DATA_W-1:0] done_value,
  input  logic [IDX_W-1:0]  query_reg,
  output logic              query_dirty,
  output logic [FLAG_W-1:0] query_flags,
  output logic              err_overflow,
  output logic              err_underflow
);
  cond_flags_t             result_flags;
  logic [CNT_W-1:0]        cnt_q   [NUM_REGS];
  cond_flags_t             flag_q  [NUM_REGS];
  logic [NUM_REGS-1:0]     ovf_vec;
  logic [NUM_REGS-1:0]     unf_vec;

  result_flag_encoder #(.DATA_W(DATA_W)) u_enc (
    .value (done_value),
    .flags (result_flags)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    logic hit_inc;
    logic hit_dec;
    assign hit_inc = disp_valid && (disp_reg == IDX_W'(i));
    assign hit_dec = done_valid && (done_reg == IDX_W'(i));

    writer_count_entry #(.CNT_W(CNT_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc       (hit_inc),
      .dec       (hit_dec),
      .new_flags (result_flags),
      .count     (cnt_q[i]),
      .flags     (flag_q[i]),
      .ovf       (ovf_vec[i]),
      .unf       (unf_vec[i])
    );
  end

  always_comb begin
    query_dirty   = (cnt_q[query_reg] != '0);
    query_flags   = flag_q[query_reg];
    err_overflow  = |ovf_vec;
    err_underflow = |unf_vec;
  end
endmodule

// File: rtl/pending_writer_table_chk.sv
module pending_writer_table_chk #(
  parameter int IDX_W  = 6,
  parameter int FLAG_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_valid,
  input logic [IDX_W-1:0]  disp_reg,
  input logic              done_valid,
  input logic [IDX_W-1:0]  done_reg,
  input logic [IDX_W-1:0]  query_reg,
  input logic              query_dirty,
  input logic [FLAG_W-1:0] query_flags,
  input logic              err_overflow,
  input logic              err_underflow
);
  logic same_pair;
  logic touch_q;
  assign same_pair = disp_valid && done_valid && (disp_reg == done_reg);
  assign touch_q   = (disp_valid && disp_reg == query_reg) ||
                     (done_valid && done_reg == query_reg);

  // R4
  flags_coherent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (query_flags[0] != query_flags[1]) &&
    (query_flags[3] == (query_flags[2] | query_flags[0])) &&
    (query_flags[5] == (query_flags[4] | query_flags[0])) &&
    !(query_flags[2] && query_flags[4]));

  // R5
  pair_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    same_pair |-> (!err_overflow && !err_underflow));

  // R6
  ovf_needs_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |-> disp_valid);

  // R7
  unf_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |-> done_valid);

  // R9
  untouched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !touch_q |=> (query_reg != $past(query_reg)) ||
                 ($stable(query_dirty) && $stable(query_flags)));

  // R2
  disp_sets_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !done_valid && disp_reg == query_reg) |=>
      (query_dirty || query_reg != $past(query_reg)));
endmodule

bind pending_writer_table pending_writer_table_chk #(
  .IDX_W(IDX_W), .FLAG_W(pwt_pkg::FLAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_reg(disp_reg),
  .done_valid(done_valid), .done_reg(done_reg), .query_reg(query_reg),
  .query_dirty(query_dirty), .query_flags(query_flags),
  .err_overflow(err_overflow), .err_underflow(err_underflow)
);

// File: tb/tb_pending_writer_table.sv
`timescale 1ns/1ps
module tb_pending_writer_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0;
  logic [5:0]  disp_reg = '0;
  logic        done_valid = 1'b0;
  logic [5:0]  done_reg = '0;
  logic [63:0] done_value = '0;
  logic [5:0]  query_reg = '0;
  logic        query_dirty;
  logic [6:0]  query_flags;
  logic        err_overflow;
  logic        err_underflow;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic seen_ovf, seen_unf;

  always #2 clk = ~clk;

  pending_writer_table dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_reg(disp_reg),
    .done_valid(done_valid), .done_reg(done_reg), .done_value(done_value),
    .query_reg(query_reg), .query_dirty(query_dirty), .query_flags(query_flags),
    .err_overflow(err_overflow), .err_underflow(err_underflow)
  );

  localparam logic [6:0] F_ZERO = 7'h29;  // eq ge le
  localparam logic [6:0] F_POS_ODD = 7'h4E;  // ne gt ge low
  localparam logic [6:0] F_POS_EVEN = 7'h0E;  // ne gt ge
  localparam logic [6:0] F_NEG_EVEN = 7'h32;  // ne lt le

  // {dv, dr, cv, cr, value, qr, exp_dirty, exp_flags}
  localparam int NV = 11;
  localparam logic [91:0] VECS [0:NV-1] = '{
    {1'b1, 6'd5,  1'b0, 6'd0,  64'd0, 6'd5,  1'b1, F_ZERO},
    {1'b1, 6'd5,  1'b0, 6'd0,  64'd0, 6'd5,  1'b1, F_ZERO},
    {1'b0, 6'd0,  1'b1, 6'd5,  64'd7, 6'd5,  1'b1, F_POS_ODD},
    {1'b0, 6'd0,  1'b1, 6'd5,  64'hFFFF_FFFF_FFFF_FFFC, 6'd5, 1'b0, F_NEG_EVEN},
    {1'b1, 6'd9,  1'b1, 6'd9,  64'd0, 6'd9,  1'b0, F_ZERO},
    {1'b1, 6'd63, 1'b0, 6'd0,  64'd0, 6'd63, 1'b1, F_ZERO},
    {1'b0, 6'd0,  1'b1, 6'd63, 64'd1, 6'd63, 1'b0, F_POS_ODD},
    {1'b1, 6'd1,  1'b0, 6'd0,  64'd0, 6'd1,  1'b1, F_ZERO},
    {1'b1, 6'd2,  1'b1, 6'd1,  64'd2, 6'd1,  1'b0, F_POS_EVEN},
    {1'b0, 6'd0,  1'b0, 6'd0,  64'd0, 6'd2,  1'b1, F_ZERO},
    {1'b0, 6'd0,  1'b0, 6'd0,  64'd0, 6'd5,  1'b0, F_NEG_EVEN}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // present one event cycle; error pulses captured before the edge
  task automatic step(input logic dv, input logic [5:0] dr, input logic cv,
                      input logic [5:0] cr, input logic [63:0] val,
                      input logic [5:0] qr);
    @(negedge clk);
    disp_valid = dv; disp_reg = dr;
    done_valid = cv; done_reg = cr; done_value = val;
    query_reg = qr;
    #1;
    seen_ovf = err_overflow;
    seen_unf = err_underflow;
    @(negedge clk);
    disp_valid = 1'b0; done_valid = 1'b0;
    #1;
  endtask

  task automatic query(input logic [5:0] qr);
    @(negedge clk);
    query_reg = qr;
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state on every register
    begin
      int bad = 0;
      for (int r = 0; r < 64; r++) begin
        query(6'(r));
        if (query_dirty !== 1'b0 || query_flags !== F_ZERO) bad++;
      end
      check("R1 reset clean/zero flags, bad regs", bad, 0);
    end

    // R2 R3 R4 R5 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [91:0] v;
      v = VECS[i];
      step(v[91], v[90:85], v[84], v[83:78], v[77:14], v[13:8]);
      check($sformatf("R2/R3/R5/R9 vec%0d dirty", i), query_dirty, v[7]);
      check($sformatf("R4 vec%0d flags", i), query_flags, v[6:0]);
      if (v[91] && v[84] && v[90:85] == v[83:78])
        check($sformatf("R5 vec%0d no error", i), seen_ovf | seen_unf, 0);
    end

    // R8 read before update: event visible only after the edge
    @(negedge clk);
    query_reg = 6'd30; disp_valid = 1'b1; disp_reg = 6'd30;
    #1;
    check("R8 same-cycle dispatch not yet visible", query_dirty, 0);
    @(negedge clk);
    disp_valid = 1'b0;
    #1;
    check("R8 dispatch visible after edge", query_dirty, 1);

    // R7 underflow: done at zero count, flags still loaded
    step(1'b0, 6'd0, 1'b1, 6'd10, 64'd5, 6'd10);
    check("R7 err_underflow pulse", seen_unf, 1);
    check("R7 count stays zero", query_dirty, 0);
    check("R7 flags loaded", query_flags, F_POS_ODD);
    check("R7 pulse gone", err_underflow, 0);

    // R6 saturate register 20
    begin
      int early = 0;
      for (int k = 0; k < 511; k++) begin
        step(1'b1, 6'd20, 1'b0, 6'd0, 64'd0, 6'd20);
        if (seen_ovf) early++;
      end
      check("R6 no overflow below max", early, 0);
    end
    step(1'b1, 6'd20, 1'b0, 6'd0, 64'd0, 6'd20);
    check("R6 err_overflow at max", seen_ovf, 1);
    step(1'b1, 6'd20, 1'b1, 6'd20, 64'd3, 6'd20);
    check("R5 pair at max no overflow", seen_ovf, 0);
    for (int k = 0; k < 510; k++)
      step(1'b0, 6'd0, 1'b1, 6'd20, 64'd0, 6'd20);
    check("R6 still dirty after 510 completions", query_dirty, 1);
    step(1'b0, 6'd0, 1'b1, 6'd20, 64'd0, 6'd20);
    check("R3 clean after 511th completion", query_dirty, 0);
    check("R7 no underflow on last drain", seen_unf, 0);

    // R1 reset again clears pending state
    step(1'b1, 6'd40, 1'b0, 6'd0, 64'd0, 6'd40);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    query(6'd40);
    check("R1 reset clears dirty", query_dirty, 0);
    query(6'd10);
    check("R1 reset restores flags", query_flags, F_ZERO);

    finish_run();
  end
endmodule